// File: doc/BRIEF.md
# Boot-Overlay Memory Map Decoder

This block sits between a 68k-style CPU's byte address bus and the memories and peripherals of an accelerator card plugged into an older host computer. For each access it raises a single chip select for one target: card ROM, card RAM, host hardware registers, card registers, the external ROM port, the host system ROM, or the extended I/O area. It also produces a write-inhibit that the RAM uses to gate its write enable, and a strobe that tells the host video hardware to take a copy of a write.

After reset the block is in boot mode. Reads of the bottom 64 KiB come from card ROM, but writes to that range land in RAM underneath it. Boot firmware uses this to copy and patch the host operating system into RAM. It then sets a bit in a card control register, which moves the block into run mode. In run mode the copied code regions read from RAM and are write-protected. A bank of firmware variables stays writable. Writes to the primary video window are copied to the host, and writes to the second video window are copied only while a second-screen bit is set.

Top module: `boot_map_decoder`

## Requirements
- R1: After reset the block is in boot mode. A read of 0x00000–0x0FFFF asserts `sel_rom`, and a write to the same range asserts `sel_ram` without `wr_inhibit`.
- R2: In boot mode, reads of 0x40000–0x4FFFF assert `sel_rom`. Accesses to 0x10000–0x17FFF, 0x1C100–0x3FFFF and 0x50000–0x3FFFFF assert `sel_ram`, and no RAM write is inhibited.
- R3: In both modes, 0x18000–0x1BFFF asserts `sel_host_io` and 0x1C000–0x1C0FF asserts `sel_card_reg`.
- R4: In both modes, 0x400000–0x40FFFF asserts `sel_sys_rom`. In boot mode, 0x410000 and above selects nothing.
- R5: The control register is at byte address 0x1C000 + `CTRL_OFS` (default 0x1C000). A write with bit 0 set enters run mode from the next clock cycle. Run mode holds until reset, and a later control write with bit 0 clear does not leave it. Every control write loads bit 1 into the second-screen enable. Reset clears both bits.
- R6: In run mode, 0x0000–0xBFFF asserts `sel_ram`, and writes there also assert `wr_inhibit`. 0xC000–0xFFFF asserts `sel_port_rom`.
- R7: In run mode, writes to 0x10000–0x17FFF and 0x1C200–0x1FFFF assert `sel_ram` with `wr_inhibit`. Writes to 0x1C100–0x1C1FF assert `sel_ram` without `wr_inhibit`.
- R8: In run mode, 0x20000–0x3FFFFF (including 0x40000–0x4FFFF) asserts `sel_ram`. 0x4C0000–0x4FFFFF asserts `sel_ext_io`. 0x410000–0x4BFFFF and 0x500000 and above select nothing.
- R9: In run mode, a write to 0x20000–0x27FFF asserts `mirror_wr`. `mirror_wr` is never asserted in boot mode or on a read.
- R10: In run mode, a write to 0x28000–0x2FFFF asserts `mirror_wr` only while the second-screen enable is 1.
- R11: At most one select is active at a time. No select is asserted when both strobes are low, when both are high, or when the address is unmapped.
- R12: `wr_inhibit` is asserted only on a write to a protected RAM region in run mode, and never on a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the control register |
| rst_n | input | 1 | Active-low asynchronous reset; returns the block to boot mode |
| addr | input | ADDR_W | Byte address of the current access |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | DATA_W | Write data, used by control register writes |
| sel_rom | output | 1 | Card ROM select |
| sel_ram | output | 1 | Card RAM select |
| sel_host_io | output | 1 | Host hardware register select |
| sel_card_reg | output | 1 | Card register select |
| sel_port_rom | output | 1 | External ROM port select |
| sel_sys_rom | output | 1 | Host system ROM select |
| sel_ext_io | output | 1 | Extended I/O area select |
| wr_inhibit | output | 1 | Blocks the RAM write of the current access |
| mirror_wr | output | 1 | Copy the current write to host video hardware |

## Verification
On every cycle, the assertions check that the select vector is one-hot or empty, and that idle or conflicting strobes select nothing. They also check that write-inhibit and mirroring occur only on RAM writes in run mode, that run mode stays set once entered, and that ROM overlay and port ROM selects appear only in their own mode. Only the bench's scenarios can show that each address range maps to the correct target at its exact boundary, that the second-screen bit switches mirroring of the second window on and off, and that run mode takes effect one cycle after the control write and is cleared by reset.

// File: rtl/bmd_pkg.sv
package bmd_pkg;

   // Fine-grained address regions; the mode decides what each one means.
   typedef enum logic [3:0] {
      RG_NONE,
      RG_LOW_SYS,
      RG_LOW_PORT,
      RG_GOLD,
      RG_HOST_IO,
      RG_CARD_REG,
      RG_FW_VAR,
      RG_PATCH,
      RG_VID1,
      RG_VID2,
      RG_RAM_MID,
      RG_ROM_MIRROR,
      RG_RAM_HI,
      RG_SYS_ROM,
      RG_EXT_IO
   } region_e;

   typedef struct packed {
      logic rom;
      logic ram;
      logic host_io;
      logic card_reg;
      logic port_rom;
      logic sys_rom;
      logic ext_io;
   } sel_t;

   localparam logic [31:0] CARD_REG_BASE = 32'h0001_C000;

   function automatic region_e classify(input logic [31:0] a);
      if      (a < 32'h0000_C000) return RG_LOW_SYS;
      else if (a < 32'h0001_0000) return RG_LOW_PORT;
      else if (a < 32'h0001_8000) return RG_GOLD;
      else if (a < 32'h0001_C000) return RG_HOST_IO;
      else if (a < 32'h0001_C100) return RG_CARD_REG;
      else if (a < 32'h0001_C200) return RG_FW_VAR;
      else if (a < 32'h0002_0000) return RG_PATCH;
      else if (a < 32'h0002_8000) return RG_VID1;
      else if (a < 32'h0003_0000) return RG_VID2;
      else if (a < 32'h0004_0000) return RG_RAM_MID;
      else if (a < 32'h0005_0000) return RG_ROM_MIRROR;
      else if (a < 32'h0040_0000) return RG_RAM_HI;
      else if (a < 32'h0041_0000) return RG_SYS_ROM;
      else if (a < 32'h004C_0000) return RG_NONE;
      else if (a < 32'h0050_0000) return RG_EXT_IO;
      else                        return RG_NONE;
   endfunction

endpackage

// File: rtl/bmd_region_decode.sv
module bmd_region_decode
   import bmd_pkg::*;
#(
   parameter int ADDR_W = 24
) (
   input  logic [ADDR_W-1:0] addr,
   output region_e           region
);
   localparam int EXT_W = 32;

   logic [EXT_W-1:0] addr_ext;

   assign addr_ext = EXT_W'(addr);
   assign region   = classify(addr_ext);

endmodule

// File: rtl/bmd_ctrl_reg.sv
module bmd_ctrl_reg #(
   parameter int DATA_W        = 8,
   parameter int RUN_BIT       = 0,
   parameter int SCR2_BIT      = 1,
   parameter bit SECOND_SCREEN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_we,
   input  logic [DATA_W-1:0] wdata,
   output logic              run_q,
   output logic              scr2_q
);
   logic unused_wdata;
   assign unused_wdata = ^wdata;

   // Run mode is sticky: only reset leaves it.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        run_q <= 1'b0;
      else if (ctrl_we && wdata[RUN_BIT]) run_q <= 1'b1;
   end

   generate
      if (SECOND_SCREEN) begin : g_scr2
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       scr2_q <= 1'b0;
            else if (ctrl_we) scr2_q <= wdata[SCR2_BIT];
         end
      end else begin : g_no_scr2
         assign scr2_q = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/bmd_access_route.sv
module bmd_access_route
   import bmd_pkg::*;
(
   input  region_e region,
   input  logic    rd_en,
   input  logic    wr_en,
   input  logic    run,
   input  logic    scr2,
   output sel_t    sel,
   output logic    wr_inhibit,
   output logic    mirror_wr
);
   logic valid;
   logic is_wr;
   sel_t pick;
   logic protect;
   logic mirror;

   assign valid = rd_en ^ wr_en;
   assign is_wr = valid & wr_en;

   always_comb begin
      pick    = '0;
      protect = 1'b0;
      mirror  = 1'b0;
      unique case (region)
         RG_LOW_SYS: begin
            if (run)        begin pick.ram = 1'b1; protect = 1'b1; end
            else if (rd_en) pick.rom = 1'b1;
            else            pick.ram = 1'b1;
         end
         RG_LOW_PORT: begin
            if (run)        pick.port_rom = 1'b1;
            else if (rd_en) pick.rom = 1'b1;
            else            pick.ram = 1'b1;
         end
         RG_GOLD, RG_PATCH: begin
            pick.ram = 1'b1;
            protect  = run;
         end
         RG_HOST_IO:  pick.host_io  = 1'b1;
         RG_CARD_REG: pick.card_reg = 1'b1;
         RG_FW_VAR:   pick.ram      = 1'b1;
         RG_VID1: begin
            pick.ram = 1'b1;
            mirror   = run;
         end
         RG_VID2: begin
            pick.ram = 1'b1;
            mirror   = run & scr2;
         end
         RG_RAM_MID, RG_RAM_HI: pick.ram = 1'b1;
         RG_ROM_MIRROR: begin
            if (run) pick.ram = 1'b1;
            else     pick.rom = 1'b1;
         end
         RG_SYS_ROM: pick.sys_rom = 1'b1;
         RG_EXT_IO:  pick.ext_io  = run;
         default:    pick = '0;
      endcase
   end

   assign sel        = valid ? pick : '0;
   assign wr_inhibit = is_wr & protect;
   assign mirror_wr  = is_wr & mirror;

endmodule

// File: rtl/boot_map_decoder.sv
module boot_map_decoder
   import bmd_pkg::*;
#(
   parameter int          ADDR_W        = 24,
   parameter int          DATA_W        = 8,
   parameter logic [7:0]  CTRL_OFS      = 8'h00,
   parameter int          RUN_BIT       = 0,
   parameter int          SCR2_BIT      = 1,
   parameter bit          SECOND_SCREEN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              rd_en,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wdata,
   output logic              sel_rom,
   output logic              sel_ram,
   output logic              sel_host_io,
   output logic              sel_card_reg,
   output logic              sel_port_rom,
   output logic              sel_sys_rom,
   output logic              sel_ext_io,
   output logic              wr_inhibit,
   output logic              mirror_wr
);
   localparam logic [31:0] CTRL_ADDR = CARD_REG_BASE + 32'(CTRL_OFS);

   generate
      if (ADDR_W < 23 || ADDR_W > 32) begin : g_bad_addr_w
         $error("boot_map_decoder: ADDR_W must be 23..32");
      end
      if (RUN_BIT >= DATA_W || SCR2_BIT >= DATA_W || RUN_BIT == SCR2_BIT) begin : g_bad_bits
         $error("boot_map_decoder: control bit positions invalid");
      end
   endgenerate

   region_e region;
   logic    run_q;
   logic    scr2_q;
   logic    ctrl_we;
   sel_t    sel;

   assign ctrl_we = wr_en & ~rd_en & (32'(addr) == CTRL_ADDR);

   bmd_region_decode #(.ADDR_W(ADDR_W)) u_region (
      .addr   (addr),
      .region (region)
   );

   bmd_ctrl_reg #(
      .DATA_W        (DATA_W),
      .RUN_BIT       (RUN_BIT),
      .SCR2_BIT      (SCR2_BIT),
      .SECOND_SCREEN (SECOND_SCREEN)
   ) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .ctrl_we (ctrl_we),
      .wdata   (wdata),
      .run_q   (run_q),
      .scr2_q  (scr2_q)
   );

   bmd_access_route u_route (
      .region     (region),
      .rd_en      (rd_en),
      .wr_en      (wr_en),
      .run        (run_q),
      .scr2       (scr2_q),
      .sel        (sel),
      .wr_inhibit (wr_inhibit),
      .mirror_wr  (mirror_wr)
   );

   assign sel_rom      = sel.rom;
   assign sel_ram      = sel.ram;
   assign sel_host_io  = sel.host_io;
   assign sel_card_reg = sel.card_reg;
   assign sel_port_rom = sel.port_rom;
   assign sel_sys_rom  = sel.sys_rom;
   assign sel_ext_io   = sel.ext_io;

endmodule

// File: rtl/bmd_checker.sv
module bmd_checker (
   input logic clk,
   input logic rst_n,
   input logic rd_en,
   input logic wr_en,
   input logic run_q,
   input logic sel_rom,
   input logic sel_ram,
   input logic sel_host_io,
   input logic sel_card_reg,
   input logic sel_port_rom,
   input logic sel_sys_rom,
   input logic sel_ext_io,
   input logic wr_inhibit,
   input logic mirror_wr
);
   logic [6:0] sels;
   assign sels = {sel_rom, sel_ram, sel_host_io, sel_card_reg,
                  sel_port_rom, sel_sys_rom, sel_ext_io};

   a_r11_one_select: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sels));

   a_r11_idle_none: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en == wr_en) |-> (sels == 7'b0));

   a_r12_inhibit_on_ram_write: assert property (@(posedge clk) disable iff (!rst_n)
      wr_inhibit |-> (wr_en && !rd_en && sel_ram && run_q));

   a_r9_mirror_run_write: assert property (@(posedge clk) disable iff (!rst_n)
      mirror_wr |-> (wr_en && !rd_en && sel_ram && run_q && !wr_inhibit));

   a_r5_run_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      run_q |=> run_q);

   a_r1_rom_only_boot: assert property (@(posedge clk) disable iff (!rst_n)
      sel_rom |-> !run_q);

   a_r6_port_only_run: assert property (@(posedge clk) disable iff (!rst_n)
      sel_port_rom |-> run_q);

   a_r8_ext_io_only_run: assert property (@(posedge clk) disable iff (!rst_n)
      sel_ext_io |-> run_q);

endmodule

bind boot_map_decoder bmd_checker u_bmd_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .rd_en        (rd_en),
   .wr_en        (wr_en),
   .run_q        (run_q),
   .sel_rom      (sel_rom),
   .sel_ram      (sel_ram),
   .sel_host_io  (sel_host_io),
   .sel_card_reg (sel_card_reg),
   .sel_port_rom (sel_port_rom),
   .sel_sys_rom  (sel_sys_rom),
   .sel_ext_io   (sel_ext_io),
   .wr_inhibit   (wr_inhibit),
   .mirror_wr    (mirror_wr)
);

// File: tb/tb_boot_map_decoder.sv
`timescale 1ns/1ps
module tb_boot_map_decoder;
   localparam int ADDR_W = 24;
   localparam int DATA_W = 8;
   localparam logic [23:0] CTRL_A = 24'h01C000;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [ADDR_W-1:0] addr = '0;
   logic              rd_en = 1'b0;
   logic              wr_en = 1'b0;
   logic [DATA_W-1:0] wdata = '0;
   logic sel_rom, sel_ram, sel_host_io, sel_card_reg;
   logic sel_port_rom, sel_sys_rom, sel_ext_io, wr_inhibit, mirror_wr;

   int errors = 0;
   int checks = 0;
   bit m_run  = 1'b0;
   bit m_scr2 = 1'b0;

   always #2.5 clk = ~clk;

   boot_map_decoder #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
      .wdata(wdata), .sel_rom(sel_rom), .sel_ram(sel_ram),
      .sel_host_io(sel_host_io), .sel_card_reg(sel_card_reg),
      .sel_port_rom(sel_port_rom), .sel_sys_rom(sel_sys_rom),
      .sel_ext_io(sel_ext_io), .wr_inhibit(wr_inhibit), .mirror_wr(mirror_wr)
   );

   // Packed as {rom, ram, host_io, card_reg, port_rom, sys_rom, ext_io, inhibit, mirror}
   function automatic logic [8:0] model(input logic [23:0] a, input bit rd,
                                        input bit wr, input bit run, input bit scr2);
      logic rom = 0, ram = 0, hio = 0, creg = 0, prom = 0, srom = 0, eio = 0;
      logic inh = 0, mir = 0;
      if (rd == wr) return 9'b0;
      if (a >= 24'h018000 && a <= 24'h01BFFF) hio = 1;
      else if (a >= 24'h01C000 && a <= 24'h01C0FF) creg = 1;
      else if (a >= 24'h400000 && a <= 24'h40FFFF) srom = 1;
      else if (!run) begin
         if (a <= 24'h00FFFF) begin rom = rd; ram = wr; end
         else if (a >= 24'h040000 && a <= 24'h04FFFF) rom = 1;
         else if (a <= 24'h3FFFFF) ram = 1;
      end else begin
         if (a <= 24'h00BFFF) begin ram = 1; inh = wr; end
         else if (a <= 24'h00FFFF) prom = 1;
         else if (a <= 24'h017FFF) begin ram = 1; inh = wr; end
         else if (a >= 24'h01C100 && a <= 24'h01C1FF) ram = 1;
         else if (a >= 24'h01C200 && a <= 24'h01FFFF) begin ram = 1; inh = wr; end
         else if (a >= 24'h020000 && a <= 24'h027FFF) begin ram = 1; mir = wr; end
         else if (a >= 24'h028000 && a <= 24'h02FFFF) begin ram = 1; mir = wr & scr2; end
         else if (a <= 24'h3FFFFF) ram = 1;
         else if (a >= 24'h4C0000 && a <= 24'h4FFFFF) eio = 1;
      end
      return {rom, ram, hio, creg, prom, srom, eio, inh, mir};
   endfunction

   function automatic string req_tag(input logic [23:0] a, input bit rd,
                                     input bit wr, input bit run);
      if (rd == wr) return "R11";
      if (a >= 24'h018000 && a <= 24'h01C0FF) return "R3";
      if (a >= 24'h400000 && a <= 24'h40FFFF) return "R4";
      if (!run) begin
         if (a <= 24'h00FFFF) return "R1";
         if (a <= 24'h3FFFFF) return "R2";
         return "R4";
      end
      if (a <= 24'h00FFFF) return "R6";
      if (a <= 24'h01FFFF) return "R7";
      if (a >= 24'h020000 && a <= 24'h027FFF) return "R9";
      if (a >= 24'h028000 && a <= 24'h02FFFF) return "R10";
      return "R8";
   endfunction

   function automatic logic [23:0] pick_addr();
      int k = int'($urandom % 40);
      case (k)
         0: return 24'h000000;  1: return 24'h000001;  2: return 24'h00BFFF;
         3: return 24'h00C000;  4: return 24'h00FFFF;  5: return 24'h010000;
         6: return 24'h017FFF;  7: return 24'h018000;  8: return 24'h01BFFF;
         9: return 24'h01C000; 10: return 24'h01C0FF; 11: return 24'h01C100;
        12: return 24'h01C1FF; 13: return 24'h01C200; 14: return 24'h01FFFF;
        15: return 24'h020000; 16: return 24'h027FFF; 17: return 24'h028000;
        18: return 24'h02FFFF; 19: return 24'h030000; 20: return 24'h03FFFF;
        21: return 24'h040000; 22: return 24'h04FFFF; 23: return 24'h050000;
        24: return 24'h3FFFFF; 25: return 24'h400000; 26: return 24'h40FFFF;
        27: return 24'h410000; 28: return 24'h4BFFFF; 29: return 24'h4C0000;
        30: return 24'h4FFFFF; 31: return 24'h500000; 32: return 24'hFFFFFF;
        default: return 24'($urandom);
      endcase
   endfunction

   // Drive on the falling edge, compare 1 ns later, model the register at the rising edge.
   task automatic access(input logic [23:0] a, input bit rd, input bit wr,
                         input logic [7:0] d, input string tag);
      logic [8:0] exp, got;
      @(negedge clk);
      addr = a; rd_en = rd; wr_en = wr; wdata = d;
      #1;
      exp = model(a, rd, wr, m_run, m_scr2);
      got = {sel_rom, sel_ram, sel_host_io, sel_card_reg, sel_port_rom,
             sel_sys_rom, sel_ext_io, wr_inhibit, mirror_wr};
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s addr=%h rd=%0b wr=%0b actual=%b expected=%b",
                  tag, a, rd, wr, got, exp);
      end
      if (wr && !rd && a == CTRL_A) begin
         if (d[0]) m_run = 1'b1;
         m_scr2 = d[1];
      end
   endtask

   task automatic random_phase(input int n, input bit allow_ctrl);
      for (int i = 0; i < n; i++) begin
         logic [23:0] a = pick_addr();
         int s = int'($urandom % 8);
         bit rd = (s == 1) || (s >= 2 && s <= 4);
         bit wr = (s == 1) || (s >= 5);
         logic [7:0] d = 8'($urandom);
         if (!allow_ctrl && a == CTRL_A) a = a + 24'd1;
         if (allow_ctrl && a == CTRL_A && wr) d[0] = 1'b1;
         access(a, rd, wr, d, req_tag(a, rd, wr, m_run));
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; rd_en = 0; wr_en = 0;
      m_run = 0; m_scr2 = 0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      #1_000_000;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      do_reset();
      // R1: reset state, boot overlay split
      access(24'h000000, 1, 0, 8'h00, "R1");
      access(24'h000000, 0, 1, 8'h00, "R1");
      access(24'h00FFFF, 1, 0, 8'h00, "R1");
      // R11: idle and conflicting strobes
      access(24'h020000, 0, 0, 8'h00, "R11");
      access(24'h020000, 1, 1, 8'h00, "R11");
      // R2, R3, R4 boundaries in boot
      access(24'h04FFFF, 1, 0, 8'h00, "R2");
      access(24'h01C100, 0, 1, 8'h00, "R2");
      access(24'h01C0FF, 1, 0, 8'h00, "R3");
      access(24'h410000, 1, 0, 8'h00, "R4");
      random_phase(300, 1'b0);
      // R9: second-screen bit set while still booting; no mirror in boot
      access(CTRL_A, 0, 1, 8'h02, "R5");
      access(24'h000000, 1, 0, 8'h00, "R5");
      access(24'h020000, 0, 1, 8'h00, "R9");
      access(24'h028000, 0, 1, 8'h00, "R9");
      // R5: enter run mode, second screen off
      access(CTRL_A, 0, 1, 8'h01, "R5");
      access(24'h000000, 1, 0, 8'h00, "R5");
      access(CTRL_A, 0, 1, 8'h00, "R5");
      access(24'h000000, 0, 1, 8'h00, "R6");
      access(24'h00C000, 1, 0, 8'h00, "R6");
      access(24'h01C1FF, 0, 1, 8'h00, "R7");
      access(24'h01C200, 0, 1, 8'h00, "R7");
      access(24'h04FFFF, 1, 0, 8'h00, "R8");
      access(24'h4C0000, 1, 0, 8'h00, "R8");
      access(24'h027FFF, 0, 1, 8'h00, "R9");
      access(24'h027FFF, 1, 0, 8'h00, "R9");
      access(24'h028000, 0, 1, 8'h00, "R10");
      access(CTRL_A, 0, 1, 8'h03, "R10");
      access(24'h02FFFF, 0, 1, 8'h00, "R10");
      access(24'h010000, 1, 0, 8'h00, "R12");
      random_phase(400, 1'b1);
      // R5: reset returns to boot
      do_reset();
      access(24'h000000, 1, 0, 8'h00, "R5");
      access(24'h4C0000, 1, 0, 8'h00, "R4");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule